// File: doc/BRIEF.md
# Feedback Power-Capping Throttle Controller

This block closes a control loop around a server's measured power draw. Power samples arrive as a stream of fixed-point words, one per `sampleValid` pulse and nominally a thousand per second. Each word is in units of 0.1 W. The block sums a power-of-two number of accepted samples into one control period and takes their floor average. It then compares that average with a programmable budget and moves a fractional throttle level by the gain times the error. Higher levels mean a faster clock duty cycle and more power, so a positive error (power under budget) raises the level.

The fractional level is held in units of 1/`LVL_DEN` of a level step, with 1/100 as the default. A first-order delta-sigma stage turns it into one integer duty-cycle level per period. The stage carries the leftover fraction forward, so the average of the emitted levels follows the fractional level much more finely than one step. The chosen integer is written to the throttle register output together with a one-cycle write strobe.

A configuration bit selects a simpler baseline mode instead of the proportional law. In that mode the level moves by exactly one whole step per period, according to the sign of the error.

Top module: `pwr_cap_throttle`

## Requirements
- R1: After reset, `throttleLvl` is 0, `lvlWrite` is 0, the internal fractional level is 0.00 and the modulator remainder is 0.
- R2: A control period ends on the 2^`LOG2N`-th cycle in which `sampleValid` is high (8 with defaults). The period uses the floor of the sum of those samples divided by 2^`LOG2N`. Cycles with `sampleValid` low contribute nothing, whatever `sampleData` holds.
- R3: In proportional mode (`stepMode`=0), each period adds floor(g*(budget - average)/128) to the fractional level, counted in units of 1/`LVL_DEN` level. Here g is the `gain` input read as unsigned Q1.7, so code 128 means 1.0.
- R4: The loop gain always lies strictly between 0 and 2. Q1.7 caps the gain below 2, and a `gain` code of 0 is treated as code 1.
- R5: After each update the fractional level is limited first to at most `maxLvl` and then to at least `minLvl`, both taken as whole levels. The minimum wins if the two cross.
- R6: In proportional mode, each period's output is the integer part of the level, plus one when the remainder plus the fractional part reaches one whole level. The remainder then keeps the excess. From reset, a steady level of 6.20 gives the output sequence 6,6,6,6,7,6,6,6,6,7.
- R7: With `stepMode`=1, the level goes up by exactly 1.00 when the error is positive, down by 1.00 when it is negative, and stays put when the error is zero, before the limits of R5. The output is the integer part of the level, and the modulator remainder is frozen.
- R8: Take the edge that accepts the last sample of a period. `throttleLvl` and `lvlWrite` change at the second rising edge after it. `lvlWrite` is high for exactly that one cycle, and `throttleLvl` does not change in any cycle without `lvlWrite`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Power sample present this cycle |
| sampleData | input | SAMPLE_W | Power sample, 0.1 W units |
| budget | input | SAMPLE_W | Power budget, 0.1 W units |
| gain | input | GAIN_W | Proportional gain, unsigned Q1.7 |
| minLvl | input | INT_W | Lowest allowed throttle level |
| maxLvl | input | INT_W | Highest allowed throttle level |
| stepMode | input | 1 | 1 selects the one-step-per-period baseline law |
| throttleLvl | output | INT_W | Integer throttle level register |
| lvlWrite | output | 1 | One-cycle strobe marking a new throttle level |

## Verification
The assertions check four things on every cycle:
- the fractional level stays inside the configured limits after each update;
- a dithered output is always the integer part of the level or one above it;
- baseline mode emits the integer part and leaves the remainder untouched;
- the output register moves only together with its single-cycle write strobe.

The bench's scenarios are needed for the things a one-cycle property cannot express:
- the arithmetic of the averaging and the proportional law;
- the floor rounding of negative corrections;
- the zero-gain substitution;
- the exact repeating dither pattern for a level of 6.20;
- the ignoring of data in cycles without a valid sample.

// File: rtl/pwr_cap_pkg.sv
package pwr_cap_pkg;

  // strobes from the period control to the datapath
  typedef struct packed {
    logic accum;    // add sampleData into the running sum
    logic ctrlUpd;  // end of period: update the fractional level, restart the sum
    logic dsUpd;    // run the modulator and write the throttle register
  } cap_strobe_t;

endpackage

// File: rtl/pwr_cap_ctrl.sv
module pwr_cap_ctrl
  import pwr_cap_pkg::*;
#(
  parameter int LOG2N = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  output cap_strobe_t stb
);

  logic [LOG2N-1:0] cntQ;
  logic             lastSample;
  logic             ctrlPendQ;
  logic             dsPendQ;

  assign lastSample = sampleValid && (cntQ == {LOG2N{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ      <= '0;
      ctrlPendQ <= 1'b0;
      dsPendQ   <= 1'b0;
    end else begin
      if (sampleValid) begin
        cntQ <= cntQ + 1'b1;
      end
      ctrlPendQ <= lastSample;
      dsPendQ   <= ctrlPendQ;
    end
  end

  always_comb begin
    stb.accum   = sampleValid;
    stb.ctrlUpd = ctrlPendQ;
    stb.dsUpd   = dsPendQ;
  end

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ctrlUpd, stb.dsUpd}));

endmodule

// File: rtl/pwr_cap_dsm.sv
module pwr_cap_dsm #(
  parameter int LVL_DEN = 100,
  parameter int LVL_W   = 11,
  parameter int INT_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dsUpd,
  input  logic             stepMode,
  input  logic [LVL_W-1:0] levelQ,
  output logic [INT_W-1:0] throttleLvl,
  output logic             lvlWrite
);

  localparam int ACC_W = $clog2(LVL_DEN);

  logic [ACC_W-1:0] accQ;
  logic [ACC_W:0]   fracPart;
  logic [INT_W-1:0] intPart;
  logic [ACC_W:0]   accSum;
  logic             carry;
  logic [ACC_W:0]   accNext;

  always_comb begin
    intPart  = INT_W'(levelQ / LVL_W'(LVL_DEN));
    fracPart = (ACC_W+1)'(levelQ % LVL_W'(LVL_DEN));
    accSum   = {1'b0, accQ} + fracPart;
    carry    = (accSum >= (ACC_W+1)'(LVL_DEN));
    accNext  = carry ? (accSum - (ACC_W+1)'(LVL_DEN)) : accSum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ        <= '0;
      throttleLvl <= '0;
      lvlWrite    <= 1'b0;
    end else begin
      lvlWrite <= dsUpd;
      if (dsUpd) begin
        if (stepMode) begin
          throttleLvl <= intPart;
        end else begin
          throttleLvl <= intPart + INT_W'(carry);
          accQ        <= accNext[ACC_W-1:0];
        end
      end
    end
  end

  // R6
  dither_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dsUpd) && !$past(stepMode)) |->
      ((throttleLvl == $past(intPart)) || (32'(throttleLvl) == 32'($past(intPart)) + 1)));

  // R7
  step_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dsUpd) && $past(stepMode)) |-> ((throttleLvl == $past(intPart)) && $stable(accQ)));

  // R8
  write_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    lvlWrite |=> !lvlWrite);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lvlWrite |-> $stable(throttleLvl));

endmodule

// File: rtl/pwr_cap_dp.sv
module pwr_cap_dp
  import pwr_cap_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int LOG2N     = 3,
  parameter int INT_W     = 4,
  parameter int LVL_DEN   = 100,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  cap_strobe_t         stb,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [SAMPLE_W-1:0] budget,
  input  logic [GAIN_W-1:0]   gain,
  input  logic [INT_W-1:0]    minLvl,
  input  logic [INT_W-1:0]    maxLvl,
  input  logic                stepMode,
  output logic [INT_W-1:0]    throttleLvl,
  output logic                lvlWrite
);

  localparam int SUM_W = SAMPLE_W + LOG2N;
  localparam int LVL_W = $clog2((1 << INT_W) * LVL_DEN);

  logic [SUM_W-1:0]    sumQ;
  logic [SAMPLE_W-1:0] avgPwr;
  logic [LVL_W-1:0]    levelQ;
  int                  errI;
  int                  gainEff;
  int                  deltaI;
  int                  minCode;
  int                  maxCode;
  int                  nextI;

  // period sum; the strobe cycle restarts it with that cycle's sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumQ <= '0;
    end else if (stb.ctrlUpd) begin
      sumQ <= stb.accum ? SUM_W'(sampleData) : '0;
    end else if (stb.accum) begin
      sumQ <= sumQ + SUM_W'(sampleData);
    end
  end

  assign avgPwr = SAMPLE_W'(sumQ >> LOG2N);

  // control law
  always_comb begin
    errI    = int'(budget) - int'(avgPwr);
    gainEff = (gain == '0) ? 1 : int'(gain);
    deltaI  = (errI * gainEff) >>> GAIN_FRAC;
    minCode = int'(minLvl) * LVL_DEN;
    maxCode = int'(maxLvl) * LVL_DEN;
    if (stepMode) begin
      if (errI > 0)      nextI = int'(levelQ) + LVL_DEN;
      else if (errI < 0) nextI = int'(levelQ) - LVL_DEN;
      else               nextI = int'(levelQ);
    end else begin
      nextI = int'(levelQ) + deltaI;
    end
    if (nextI > maxCode) nextI = maxCode;
    if (nextI < minCode) nextI = minCode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= '0;
    end else if (stb.ctrlUpd) begin
      levelQ <= LVL_W'(nextI);
    end
  end

  pwr_cap_dsm #(
    .LVL_DEN (LVL_DEN),
    .LVL_W   (LVL_W),
    .INT_W   (INT_W)
  ) u_dsm (
    .clk         (clk),
    .rstN        (rstN),
    .dsUpd       (stb.dsUpd),
    .stepMode    (stepMode),
    .levelQ      (levelQ),
    .throttleLvl (throttleLvl),
    .lvlWrite    (lvlWrite)
  );

  // R5
  lvl_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.ctrlUpd) |-> (int'(levelQ) >= $past(minCode)));

  // R5
  lvl_ceil_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stb.ctrlUpd) && ($past(minCode) <= $past(maxCode))) |->
      (int'(levelQ) <= $past(maxCode)));

  // R3
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.ctrlUpd) |-> $stable(levelQ));

endmodule

// File: rtl/pwr_cap_throttle.sv
module pwr_cap_throttle
  import pwr_cap_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int LOG2N     = 3,
  parameter int INT_W     = 4,
  parameter int LVL_DEN   = 100,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [SAMPLE_W-1:0] budget,
  input  logic [GAIN_W-1:0]   gain,
  input  logic [INT_W-1:0]    minLvl,
  input  logic [INT_W-1:0]    maxLvl,
  input  logic                stepMode,
  output logic [INT_W-1:0]    throttleLvl,
  output logic                lvlWrite
);

  cap_strobe_t stb;

  pwr_cap_ctrl #(
    .LOG2N (LOG2N)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .stb         (stb)
  );

  pwr_cap_dp #(
    .SAMPLE_W  (SAMPLE_W),
    .LOG2N     (LOG2N),
    .INT_W     (INT_W),
    .LVL_DEN   (LVL_DEN),
    .GAIN_W    (GAIN_W),
    .GAIN_FRAC (GAIN_FRAC)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .sampleData  (sampleData),
    .budget      (budget),
    .gain        (gain),
    .minLvl      (minLvl),
    .maxLvl      (maxLvl),
    .stepMode    (stepMode),
    .throttleLvl (throttleLvl),
    .lvlWrite    (lvlWrite)
  );

endmodule

// File: tb/pwr_cap_throttle_tb.sv
module pwr_cap_throttle_tb;

  localparam int NSAMP = 8;
  localparam int DEN   = 100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleData = '0;
  logic [15:0] budget = '0;
  logic [7:0]  gain = '0;
  logic [3:0]  minLvl = '0;
  logic [3:0]  maxLvl = '0;
  logic        stepMode = 1'b0;
  logic [3:0]  throttleLvl;
  logic        lvlWrite;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int mL, mAcc, mOut;

  pwr_cap_throttle u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .budget(budget), .gain(gain), .minLvl(minLvl), .maxLvl(maxLvl),
    .stepMode(stepMode), .throttleLvl(throttleLvl), .lvlWrite(lvlWrite)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lawDelta(int avg);
    int e, g;
    e = int'(budget) - avg;
    g = (gain == 0) ? 1 : int'(gain);
    return (e * g) >>> 7;
  endfunction

  // expected level, remainder and output after one period
  task automatic modelPeriod(input int avg);
    int e, n, s;
    e = int'(budget) - avg;
    if (stepMode) n = mL + ((e > 0) ? DEN : (e < 0) ? -DEN : 0);
    else          n = mL + lawDelta(avg);
    if (n > int'(maxLvl) * DEN) n = int'(maxLvl) * DEN;
    if (n < int'(minLvl) * DEN) n = int'(minLvl) * DEN;
    mL = n;
    if (stepMode) begin
      mOut = mL / DEN;
    end else begin
      s = mAcc + (mL % DEN);
      if (s >= DEN) begin mOut = mL / DEN + 1; mAcc = s - DEN; end
      else          begin mOut = mL / DEN;     mAcc = s;       end
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0; sampleValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset throttleLvl", int'(throttleLvl), 0);
    check("R1 reset lvlWrite", int'(lvlWrite), 0);
    rstN = 1'b1;
    mL = 0; mAcc = 0; mOut = 0;
  endtask

  // one period: samples base+/-spread, optional idle gaps with junk data
  task automatic runPeriod(input string req, input int base, input int spread, input bit gaps);
    int sum, v;
    sum = 0;
    for (int i = 0; i < NSAMP; i++) begin
      if (gaps && ($urandom_range(0, 2) == 0)) begin
        @(negedge clk);
        sampleValid = 1'b0;
        sampleData = 16'($urandom_range(0, 65535));   // R2: must be ignored
      end
      @(negedge clk);
      v = base + ((spread > 0) ? $urandom_range(0, 2 * spread) - spread : 0);
      if (v < 0) v = 0;
      sampleValid = 1'b1;
      sampleData = 16'(v);
      sum += v;
    end
    @(negedge clk);
    sampleValid = 1'b0;
    sampleData = 16'hFFFF;
    @(negedge clk);
    check({req, " R8 hold before write"}, int'(throttleLvl), mOut);
    check({req, " R8 no early strobe"}, int'(lvlWrite), 0);
    modelPeriod(sum / NSAMP);
    @(negedge clk);
    check({req, " R8 strobe"}, int'(lvlWrite), 1);
    check({req, " level"}, int'(throttleLvl), mOut);
  endtask

  initial begin
    int pat[10] = '{6, 6, 6, 6, 7, 6, 6, 6, 6, 7};
    void'($urandom(32'd20240611));
    budget = 16'd2000; gain = 8'd128; minLvl = 4'd0; maxLvl = 4'd15; stepMode = 1'b0;
    applyReset();

    // R6: reach 6.20 in one period, then hold with zero error
    runPeriod("R3 step to 6.20", 1380, 0, 1'b0);
    check("R6 pattern 0", int'(throttleLvl), pat[0]);
    for (int k = 1; k < 10; k++) begin
      runPeriod("R6 steady", 2000, 0, 1'b0);
      check($sformatf("R6 pattern %0d", k), int'(throttleLvl), pat[k]);
    end

    // R2: gaps with junk data, spread averaging
    for (int k = 0; k < 4; k++) runPeriod("R2 gapped average", 1990, 40, 1'b1);

    // R4: gain code 0 acts as 1/128
    gain = 8'd0;
    runPeriod("R4 zero gain", 1744, 0, 1'b0);
    runPeriod("R4 zero gain negative", 2300, 0, 1'b0);

    // R5: ceiling then floor
    gain = 8'd255; budget = 16'd4000; maxLvl = 4'd9; minLvl = 4'd3;
    runPeriod("R5 ceiling", 1000, 0, 1'b0);
    check("R5 at max", int'(throttleLvl), 9);
    budget = 16'd1000;
    runPeriod("R5 floor", 4000, 0, 1'b0);
    check("R5 at min", int'(throttleLvl), 3);
    minLvl = 4'd10; budget = 16'd2000;
    runPeriod("R5 min wins", 2000, 0, 1'b0);
    check("R5 crossed limits", int'(throttleLvl), 10);

    // R7: baseline single steps
    minLvl = 4'd0; maxLvl = 4'd15; stepMode = 1'b1;
    runPeriod("R7 down", 2100, 0, 1'b0);
    check("R7 down one", int'(throttleLvl), 9);
    runPeriod("R7 hold", 2000, 0, 1'b0);
    check("R7 hold zero error", int'(throttleLvl), 9);
    runPeriod("R7 up", 1990, 0, 1'b0);
    check("R7 up one", int'(throttleLvl), 10);
    maxLvl = 4'd10;
    runPeriod("R7 clamp", 1500, 0, 1'b0);
    check("R7 clamped at max", int'(throttleLvl), 10);

    // R3: random configurations
    for (int k = 0; k < 60; k++) begin
      int lo;
      lo = $urandom_range(0, 7);
      minLvl = 4'(lo);
      maxLvl = 4'(lo + $urandom_range(0, 8));
      gain = ($urandom_range(0, 7) == 0) ? 8'd0 : 8'($urandom_range(1, 255));
      stepMode = ($urandom_range(0, 3) == 0);
      budget = 16'($urandom_range(1500, 2600));
      runPeriod(stepMode ? "R7 random" : "R3 random", int'(budget) + $urandom_range(0, 600) - 300,
                50, $urandom_range(0, 1) == 1);
    end

    applyReset();
    check("R1 after reset level", int'(throttleLvl), 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule